// File: doc/BRIEF.md
# Paged Memory Window Controller

This block connects a host register bus to a 16 MB single-ported shared memory that a target processor also uses. The host cannot address the whole memory. It sees a 1 MB window, and a host-writable page field chooses which megabyte of the memory that window shows. The same host bus reaches a small register space. That space holds the page register and a reset control register. The reset control register drives the target processor's reset line and its non-maskable interrupt line.

The memory has one port, so the block grants it to a single requester per cycle. The target processor always wins. When a host window request collides with target traffic, it is held off until a cycle in which the target is not requesting.

A host transfer is a level request (`hst_req`) that the host holds until a one-cycle `hst_ack`. Memory reads take one cycle, so both window read data and register read data appear on `hst_rdata` in the acknowledge cycle. Bit 20 of the host address selects the window (1) or the register space (0).

Top module: `pmw_ctrl`

## Requirements
- R1: After a synchronous active-low reset the page is 0, `cpu_rst` is 1, `cpu_nmi` is 0, the NMI is disarmed and `hst_ack` is 0.
- R2: A host window access drives `mem_addr` = {page[3:0], hst_addr[19:0]}.
- R3: The page register is at register index 0 (hst_addr[20]=0, hst_addr[3:2]=0). It is written and read by the host with the page in data bits 23..20. Other written bits are ignored and read back as 0. The page changes only on a write to this register.
- R4: The target has fixed priority. While `tgt_req` is 1, no host window access reaches the memory, and a pending host window request waits exactly as many cycles as `tgt_req` stays high.
- R5: A granted host window access is acknowledged one cycle later. On a read, `hst_rdata` in that cycle holds the memory word at the mapped address. A host window write stores `hst_wdata` there.
- R6: The reset control register is at register index 1. Its bit 1 drives `cpu_rst`: 1 holds the target in reset and 0 releases it. The line changes only on a write to this register.
- R7: Bit 2 of the reset control register arms the NMI when written 1. A later write with bit 2 = 0 while armed produces `cpu_nmi` high for exactly one cycle, seen in the acknowledge cycle. Writing 0 while disarmed, or writing 1, produces no pulse.
- R8: The reset control register is write-only, and a host read of it returns 0.
- R9: Each host request makes at most one memory access and one single-cycle `hst_ack`. A target request reaches the memory in the same cycle with its own address, write enable and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_req | input | 1 | Host transfer request, held until acknowledge |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | 21 | Bit 20: window/register select; bits 19..0 window offset; bits 3..2 register index |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | One-cycle transfer completion |
| hst_rdata | output | 32 | Host read data, valid with hst_ack |
| tgt_req | input | 1 | Target memory request (always served) |
| tgt_we | input | 1 | Target write enable |
| tgt_addr | input | 24 | Target memory address |
| tgt_wdata | input | 32 | Target write data |
| tgt_rdata | output | 32 | Target read data, cycle after the request |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_en |
| cpu_rst | output | 1 | Target processor reset |
| cpu_nmi | output | 1 | Target processor NMI pulse |

## Verification
On every cycle, the assertions check four properties: a host grant never coincides with a target request, a target request routes its own address to the memory, `hst_ack` and `cpu_nmi` never last beyond one cycle, and the page and reset line change only on register writes. Other behaviour needs the bench's scenarios. These include the exact mapped address and the data returned through the window across random pages, and the stall length under a forced target burst. They also include the arm-then-clear NMI sequence against clears while disarmed, and the read-back values of both registers.

// File: rtl/pmw_pkg.sv
// Shared definitions for the paged memory window controller.
// Assumes: register index comes from host address bits 3..2.
package pmw_pkg;
    typedef enum logic [1:0] {
        RSEL_PAGE   = 2'd0,
        RSEL_RSTCTL = 2'd1,
        RSEL_SPARE2 = 2'd2,
        RSEL_SPARE3 = 2'd3
    } reg_sel_e;

    localparam int RSTCTL_RST_BIT = 1;
    localparam int RSTCTL_NMI_BIT = 2;

    typedef struct packed {
        logic     win;
        reg_sel_e sel;
    } host_dec_t;
endpackage

// File: rtl/pmw_regs.sv
// Page register and reset control register.
// Holds the window page, the target reset level and the NMI arm bit.
// Makes a one-cycle NMI pulse when an armed NMI bit is cleared.
// Assumes: write strobes are single-cycle and come from pmw_hostif.
module pmw_regs #(
    parameter int DATA_W   = 32,
    parameter int PAGE_W   = 4,
    parameter int PAGE_LSB = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr,
    input  logic              rstctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0] page,
    output logic              cpu_rst,
    output logic              cpu_nmi
);
    import pmw_pkg::*;

    logic [PAGE_W-1:0] page_q;
    logic              rst_q;
    logic              arm_q;
    logic              nmi_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    // Page field capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (page_wr) page_q <= wdata[PAGE_LSB +: PAGE_W];
    end

    // Reset level, NMI arm bit and NMI pulse on the armed-to-clear edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b1;
            arm_q <= 1'b0;
            nmi_q <= 1'b0;
        end else if (rstctl_wr) begin
            rst_q <= wdata[RSTCTL_RST_BIT];
            arm_q <= wdata[RSTCTL_NMI_BIT];
            nmi_q <= arm_q && !wdata[RSTCTL_NMI_BIT];
        end else begin
            nmi_q <= 1'b0;
        end
    end

    assign page    = page_q;
    assign cpu_rst = rst_q;
    assign cpu_nmi = nmi_q;

    AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_nmi |=> !cpu_nmi); // R7
    AST_NMI_WAS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_nmi) |-> $past(arm_q)); // R7
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(page_wr) |-> $stable(page)); // R3
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rstctl_wr) |-> $stable(cpu_rst)); // R6
endmodule

// File: rtl/pmw_arb.sv
// Single-port memory arbiter and address former.
// The target always wins. The host window is served only in cycles with no target request.
// Forms the window address as {page, offset}.
// Assumes: purely combinational; the memory has one-cycle read latency.
module pmw_arb #(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 24,
    parameter int WIN_AW = 20,
    localparam int PAGE_W = MEM_AW - WIN_AW
) (
    input  logic              tgt_req,
    input  logic              tgt_we,
    input  logic [MEM_AW-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_wdata,
    input  logic              win_req,
    input  logic              win_we,
    input  logic [WIN_AW-1:0] win_off,
    input  logic [DATA_W-1:0] win_wdata,
    input  logic [PAGE_W-1:0] page,
    output logic              win_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    // Fixed-priority grant and memory port steering.
    always_comb begin
        win_gnt = win_req && !tgt_req;
        if (tgt_req) begin
            mem_en    = 1'b1;
            mem_we    = tgt_we;
            mem_addr  = tgt_addr;
            mem_wdata = tgt_wdata;
        end else begin
            mem_en    = win_gnt;
            mem_we    = win_gnt && win_we;
            mem_addr  = {page, win_off};
            mem_wdata = win_wdata;
        end
    end
endmodule

// File: rtl/pmw_hostif.sv
// Host bus decoder and completion logic.
// Splits requests into window and register traffic and issues one access per request.
// Returns read data together with a one-cycle acknowledge.
// Assumes: the host holds hst_req until it sees hst_ack.
module pmw_hostif #(
    parameter int DATA_W   = 32,
    parameter int WIN_AW   = 20,
    parameter int PAGE_W   = 4,
    parameter int PAGE_LSB = 20,
    localparam int HOST_AW = WIN_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic [HOST_AW-1:0] hst_addr,
    output logic               hst_ack,
    output logic [DATA_W-1:0]  hst_rdata,
    input  logic               win_gnt,
    input  logic               tgt_req,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [PAGE_W-1:0]  page,
    output logic               win_req,
    output logic               win_we,
    output logic [WIN_AW-1:0]  win_off,
    output logic               page_wr,
    output logic               rstctl_wr
);
    import pmw_pkg::*;

    host_dec_t         dec;
    logic              ack_q;
    logic              rd_win_q;
    logic [DATA_W-1:0] reg_rdata_q;
    logic              reg_go;
    logic [DATA_W-1:0] reg_rdata_d;

    // Address decode and request qualification (no reissue in the ack cycle).
    always_comb begin
        dec.win     = hst_addr[WIN_AW];
        dec.sel     = reg_sel_e'(hst_addr[3:2]);
        win_req     = hst_req && dec.win && !ack_q;
        win_we      = hst_we;
        win_off     = hst_addr[WIN_AW-1:0];
        reg_go      = hst_req && !dec.win && !ack_q;
        page_wr     = reg_go && hst_we && (dec.sel == RSEL_PAGE);
        rstctl_wr   = reg_go && hst_we && (dec.sel == RSEL_RSTCTL);
        reg_rdata_d = '0;
        if (dec.sel == RSEL_PAGE) reg_rdata_d[PAGE_LSB +: PAGE_W] = page;
    end

    // Completion state: acknowledge, read source and register read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q       <= 1'b0;
            rd_win_q    <= 1'b0;
            reg_rdata_q <= '0;
        end else begin
            ack_q       <= (win_req && win_gnt) || reg_go;
            rd_win_q    <= win_req && win_gnt && !hst_we;
            reg_rdata_q <= reg_rdata_d;
        end
    end

    assign hst_ack   = ack_q;
    assign hst_rdata = rd_win_q ? mem_rdata : reg_rdata_q;

    AST_HOST_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        win_gnt |-> !tgt_req); // R4
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |=> !hst_ack); // R9
    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hst_ack) |-> $past(hst_req)); // R5
endmodule

// File: rtl/pmw_ctrl.sv
// Paged memory window controller top.
// Ties the host decoder, the register file and the memory arbiter together.
// Assumes: the external memory is synchronous with one-cycle read latency.
module pmw_ctrl #(
    parameter int DATA_W   = 32,
    parameter int MEM_AW   = 24,
    parameter int WIN_AW   = 20,
    localparam int PAGE_W  = MEM_AW - WIN_AW,
    localparam int HOST_AW = WIN_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [DATA_W-1:0]  hst_wdata,
    output logic               hst_ack,
    output logic [DATA_W-1:0]  hst_rdata,
    input  logic               tgt_req,
    input  logic               tgt_we,
    input  logic [MEM_AW-1:0]  tgt_addr,
    input  logic [DATA_W-1:0]  tgt_wdata,
    output logic [DATA_W-1:0]  tgt_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               cpu_rst,
    output logic               cpu_nmi
);
    localparam int PAGE_LSB = WIN_AW;

    logic              win_req;
    logic              win_we;
    logic              win_gnt;
    logic [WIN_AW-1:0] win_off;
    logic              page_wr;
    logic              rstctl_wr;
    logic [PAGE_W-1:0] page;

    pmw_hostif #(.DATA_W(DATA_W), .WIN_AW(WIN_AW), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)) u_hostif (
        .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_ack(hst_ack), .hst_rdata(hst_rdata), .win_gnt(win_gnt), .tgt_req(tgt_req),
        .mem_rdata(mem_rdata), .page(page), .win_req(win_req), .win_we(win_we),
        .win_off(win_off), .page_wr(page_wr), .rstctl_wr(rstctl_wr)
    );

    pmw_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .rstctl_wr(rstctl_wr),
        .wdata(hst_wdata), .page(page), .cpu_rst(cpu_rst), .cpu_nmi(cpu_nmi)
    );

    pmw_arb #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .WIN_AW(WIN_AW)) u_arb (
        .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .win_req(win_req), .win_we(win_we), .win_off(win_off), .win_wdata(hst_wdata),
        .page(page), .win_gnt(win_gnt), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign tgt_rdata = mem_rdata;

    AST_TGT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> (mem_en && mem_addr == tgt_addr && mem_we == tgt_we)); // R9
endmodule

// File: tb/tb_pmw_ctrl.sv
module tb_pmw_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 1'b0, hst_we = 1'b0;
    logic [20:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_ack;
    logic [31:0] hst_rdata;
    logic        tgt_req = 1'b0, tgt_we = 1'b0;
    logic [23:0] tgt_addr = '0;
    logic [31:0] tgt_wdata = '0;
    logic [31:0] tgt_rdata;
    logic        mem_en, mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        cpu_rst, cpu_nmi;

    int checks = 0, fails = 0, nmi_cnt = 0, tgt_mode = 0;
    bit done = 0;
    logic [31:0] arr [1024];
    logic [31:0] shadow [1024];
    logic [3:0]  exp_page = '0;

    always #4 clk = ~clk;

    pmw_ctrl dut (.*);

    function automatic int midx(input logic [23:0] a);
        return int'({a[23:20], a[5:0]});
    endfunction

    function automatic logic [31:0] seed_word(input int i);
        return 32'hA5000000 ^ (i * 32'h00010203);
    endfunction

    // Bench memory: synchronous, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= arr[midx(mem_addr)];
            if (mem_we) arr[midx(mem_addr)] <= mem_wdata;
        end
    end

    always @(posedge clk) if (rst_n && cpu_nmi) nmi_cnt++;

    // Target traffic generator: 0 idle, 1 random, 2 held on.
    always @(negedge clk) begin
        tgt_req  = (tgt_mode == 2) || (tgt_mode == 1 && ($urandom % 3 == 0));
        tgt_addr = 24'($urandom);
        tgt_we   = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic [20:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output logic [23:0] seen, output int stalls);
        stalls = 0;
        seen   = '1;
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
        forever begin
            #3;
            if (hst_ack) begin
                rd = hst_rdata;
                break;
            end
            if (tgt_req) begin
                stalls++;
                chk(mem_addr == tgt_addr, "R9 target address routed", {8'h0, mem_addr}, {8'h0, tgt_addr});
            end else if (mem_en) begin
                seen = mem_addr;
            end
            @(negedge clk);
        end
        hst_req = 1'b0;
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
        logic [31:0] rd; logic [23:0] s; int st;
        host_op(1'b1, {1'b0, 16'h0, sel, 2'b00}, d, rd, s, st);
    endtask

    task automatic reg_rd(input logic [1:0] sel, output logic [31:0] rd);
        logic [23:0] s; int st;
        host_op(1'b0, {1'b0, 16'h0, sel, 2'b00}, 32'h0, rd, s, st);
    endtask

    task automatic win_op(input logic we, input logic [19:0] off, input logic [31:0] d, input string tag);
        logic [31:0] rd; logic [23:0] s; int st; int i;
        i = midx({exp_page, off});
        host_op(we, {1'b1, off}, d, rd, s, st);
        chk(s == {exp_page, off}, "R2 mapped address", {8'h0, s}, {8'h0, exp_page, off});
        if (we) shadow[i] = d;
        else    chk(rd == shadow[i], tag, rd, shadow[i]);
    endtask

    initial begin
        logic [31:0] rd; logic [23:0] s; int st; int n0;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 1024; i++) begin
            arr[i] = seed_word(i);
            shadow[i] = seed_word(i);
        end
        repeat (4) @(negedge clk);
        #3;
        chk(cpu_rst == 1'b1, "R1 reset holds cpu_rst", {31'h0, cpu_rst}, 32'h1);
        chk(cpu_nmi == 1'b0, "R1 reset nmi low", {31'h0, cpu_nmi}, 32'h0);
        chk(hst_ack == 1'b0, "R1 reset ack low", {31'h0, hst_ack}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        reg_rd(2'd0, rd);
        chk(rd == 32'h0, "R1 page zero after reset", rd, 32'h0);
        // R1 NMI disarmed: clearing bit 2 right after reset gives no pulse
        n0 = nmi_cnt;
        reg_wr(2'd1, 32'h2);
        repeat (2) @(negedge clk);
        chk(nmi_cnt == n0, "R1 nmi disarmed after reset", nmi_cnt, n0);

        // R3 page field, junk bits ignored
        reg_wr(2'd0, 32'hFF_A5_FF_FF);
        exp_page = 4'hA;
        reg_rd(2'd0, rd);
        chk(rd == 32'h00A0_0000, "R3 page readback", rd, 32'h00A0_0000);
        win_op(1'b1, 20'h12345, 32'hDEAD_BEEF, "R5 write");
        win_op(1'b0, 20'h12345, 32'h0, "R5 read after write");
        win_op(1'b0, 20'hFFFC0, 32'h0, "R5 read seed word");

        // R6 reset release and reassert
        reg_wr(2'd1, 32'h0);
        #3; chk(cpu_rst == 1'b0, "R6 reset released", {31'h0, cpu_rst}, 32'h0);
        reg_wr(2'd1, 32'h2);
        #3; chk(cpu_rst == 1'b1, "R6 reset asserted", {31'h0, cpu_rst}, 32'h1);
        reg_wr(2'd1, 32'h0);

        // R8 write-only register reads zero
        reg_wr(2'd1, 32'h4);
        reg_rd(2'd1, rd);
        chk(rd == 32'h0, "R8 reset control reads zero", rd, 32'h0);

        // R7 arm (above, no pulse on arming), then clear: one pulse in ack cycle
        chk(nmi_cnt == n0, "R7 no pulse when arming", nmi_cnt, n0);
        host_op(1'b1, 21'h4, 32'h0, rd, s, st);
        chk(cpu_nmi == 1'b1, "R7 pulse in ack cycle", {31'h0, cpu_nmi}, 32'h1);
        @(negedge clk); #3;
        chk(cpu_nmi == 1'b0, "R7 pulse ends", {31'h0, cpu_nmi}, 32'h0);
        chk(nmi_cnt == n0 + 1, "R7 exactly one pulse", nmi_cnt, n0 + 1);
        reg_wr(2'd1, 32'h0);
        repeat (2) @(negedge clk);
        chk(nmi_cnt == n0 + 1, "R7 clear while disarmed", nmi_cnt, n0 + 1);

        // R4 forced target burst: exact stall length
        tgt_mode = 2;
        @(negedge clk);
        fork
            host_op(1'b0, {1'b1, 20'h12345}, 32'h0, rd, s, st);
            begin repeat (4) @(negedge clk); #1 tgt_mode = 0; end
        join
        chk(st == 4, "R4 stall cycles", st, 4);
        chk(rd == 32'hDEAD_BEEF, "R4 data after stall", rd, 32'hDEAD_BEEF);

        // R9 no second access after ack
        @(negedge clk); #3;
        chk(!hst_ack && !mem_en, "R9 single access per request", {30'h0, hst_ack, mem_en}, 32'h0);

        // Random mix with target traffic
        tgt_mode = 1;
        for (int k = 0; k < 300; k++) begin
            int c;
            c = $urandom % 8;
            if (c == 0) begin
                logic [3:0] p;
                p = 4'($urandom);
                reg_wr(2'd0, {8'($urandom), p, 20'($urandom)});
                exp_page = p;
            end else if (c == 1) begin
                reg_rd(2'd0, rd);
                chk(rd == {8'h0, exp_page, 20'h0}, "R3 random page readback", rd, {8'h0, exp_page, 20'h0});
            end else begin
                win_op(c[0], 20'($urandom), $urandom, "R5 random window read");
            end
        end
        tgt_mode = 0;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule